// File: doc/BRIEF.md
# Loss-of-Signal Monitor with Reference Clock Fallback

This block sits beside a clock-recovery loop. It samples the incoming line stream on the recovered clock and times how long the stream stays without a level change. When that quiet run grows long enough, it declares loss of signal and moves the clock-source select from the recovered data to the local reference.

Other causes can also force the reference source, and each acts on its own. An analog amplitude comparator can force loss of signal. In NRZ operation, an optical receiver's signal-detect line going low forces the reference source. A test-clock enable bypasses recovery altogether.

A divide-by-eight counter brings the recovered clock down to the reference rate so that the two can be compared outside the block. All outputs are registered. Reset starts the block in the loss-of-signal state with the reference selected.

Top module: `los_fallback_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `los_o` = 1, `ref_sel_o` = 1 (1 means the reference clock) and `div_clk_o` = 0.
- R2: After the last sampled change of `line_i`, `los_o` stays 0 for at least 96 clock cycles and is 1 no later than 224 cycles later, provided no cause forces it.
- R3: Quiet time is counted in ticks of 32 cycles from a free-running prescaler. Loss of signal is declared once 4 ticks pass with no transition, and it stays declared for as long as the line stays quiet.
- R4: A change on `line_i` sampled at edge k clears the data-path loss of signal. `los_o` is still 1 after edge k+1 and is 0 after edge k+2, unless `ana_los_i` is high.
- R5: `ana_los_i` = 1 sets both `los_o` and `ref_sel_o` to 1 on the next edge, whatever the line activity.
- R6: `test_clk_en_i` = 1 sets `ref_sel_o` to 1 on the next edge and has no effect on `los_o`.
- R7: With `cmi_mode_i` = 0 (NRZ), `sig_det_i` = 0 sets `ref_sel_o` to 1 on the next edge without changing `los_o`. With `cmi_mode_i` = 1 (CMI), `sig_det_i` is ignored.
- R8: `ref_sel_o` is 0 only when there is no data-path loss of signal, `ana_los_i` is low, `test_clk_en_i` is low, and the NRZ signal-detect cause is inactive. Whenever `los_o` is 1, `ref_sel_o` is 1.
- R9: `div_clk_o` has a period of 8 clock cycles, with 4 cycles high and 4 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Line stream sample |
| ana_los_i | input | 1 | Analog comparator loss indication, high = loss |
| sig_det_i | input | 1 | Optical signal detect, low = no light |
| cmi_mode_i | input | 1 | 1 = CMI line coding, 0 = NRZ |
| test_clk_en_i | input | 1 | Test bypass, forces the reference source |
| los_o | output | 1 | Loss-of-signal status |
| ref_sel_o | output | 1 | Clock source: 1 = reference, 0 = recovered data |
| div_clk_o | output | 1 | Recovered clock divided by 8 |

## Verification
The bench drives the line in four patterns. A single change followed by silence brackets the declaration time against the 96 and 224 cycle bounds. A long silence shows the status holding. A change every 80 cycles shows that activity just under the threshold never lets the status rise. A change on every cycle shows that dense activity keeps the status clear. Each forcing input is then raised alone on a live line, so that its effect on the source select is separated from its effect on the status. This includes signal detect in both coding modes. The divided clock is measured for high time and rising-edge count over a 64-cycle window.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_REF  = 1'b1
  } clk_src_e;
endpackage

// File: rtl/los_edge_det.sv
module los_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic trans_o
);
  logic d1_q, d2_q, v1_q, v2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1_q <= 1'b0;
      d2_q <= 1'b0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      d1_q <= line_i;
      d2_q <= d1_q;
      v1_q <= 1'b1;
      v2_q <= v1_q;
    end
  end

  // a change is only trusted once both history stages hold real samples
  assign trans_o = v2_q & (d1_q ^ d2_q);
endmodule

// File: rtl/los_quiet_timer.sv
module los_quiet_timer #(
  parameter int TICK_LEN = 32,
  parameter int TICKS    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trans_i,
  output logic data_los_o
);
  localparam int PW = (TICK_LEN > 1) ? $clog2(TICK_LEN) : 1;
  localparam int TW = $clog2(TICKS + 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tcnt_q;
  logic          tick;

  assign tick = (pre_q == PW'(TICK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q <= TW'(TICKS);
    end else if (trans_i) begin
      tcnt_q <= '0;
    end else if (tick && (tcnt_q != TW'(TICKS))) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign data_los_o = (tcnt_q == TW'(TICKS));

  // R3
  tick_sat_chk: assert property (@(posedge clk) disable iff (rst)
    tcnt_q <= TW'(TICKS));
  // R4
  trans_clear_chk: assert property (@(posedge clk) disable iff (rst)
    trans_i |=> !data_los_o);
  // R3
  los_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (data_los_o && !trans_i) |=> data_los_o);
endmodule

// File: rtl/los_ref_div.sv
module los_ref_div #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  output logic div_o
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_o <= 1'b0;
    end else if (cnt_q == DW'(HALF - 1)) begin
      cnt_q <= '0;
      div_o <= ~div_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  div_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_o) |-> (cnt_q == '0));
endmodule

// File: rtl/los_fallback_ctrl.sv
module los_fallback_ctrl #(
  parameter int TICK_LEN  = 32,
  parameter int TICKS     = 4,
  parameter int DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic ana_los_i,
  input  logic sig_det_i,
  input  logic cmi_mode_i,
  input  logic test_clk_en_i,
  output logic los_o,
  output logic ref_sel_o,
  output logic div_clk_o
);
  import los_pkg::*;

  logic     trans;
  logic     data_los;
  logic     los_d;
  logic     nrz_dark;
  clk_src_e src_d;

  los_edge_det u_edge (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .trans_o (trans)
  );

  los_quiet_timer #(
    .TICK_LEN (TICK_LEN),
    .TICKS    (TICKS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .trans_i    (trans),
    .data_los_o (data_los)
  );

  los_ref_div #(
    .DIV_RATIO (DIV_RATIO)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .div_o (div_clk_o)
  );

  always_comb begin
    los_d    = data_los | ana_los_i;
    nrz_dark = ~cmi_mode_i & ~sig_det_i;
    src_d    = (los_d | nrz_dark | test_clk_en_i) ? SRC_REF : SRC_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      los_o     <= 1'b1;
      ref_sel_o <= SRC_REF;
    end else begin
      los_o     <= los_d;
      ref_sel_o <= src_d;
    end
  end

  // R5
  ana_force_chk: assert property (@(posedge clk) disable iff (rst)
    ana_los_i |=> (los_o && ref_sel_o));
  // R6
  test_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    test_clk_en_i |=> ref_sel_o);
  // R7
  nrz_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmi_mode_i && !sig_det_i) |=> ref_sel_o);
  // R8
  los_implies_ref_chk: assert property (@(posedge clk) disable iff (rst)
    los_o |-> ref_sel_o);
  // R2
  data_los_seen_chk: assert property (@(posedge clk) disable iff (rst)
    data_los |=> los_o);
endmodule

// File: tb/los_fallback_ctrl_tb_top.sv
module los_fallback_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst, line_i, ana_los_i, sig_det_i, cmi_mode_i, test_clk_en_i;
  logic los_o, ref_sel_o, div_clk_o;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  los_fallback_ctrl dut_i (
    .clk           (clk),
    .rst           (rst),
    .line_i        (line_i),
    .ana_los_i     (ana_los_i),
    .sig_det_i     (sig_det_i),
    .cmi_mode_i    (cmi_mode_i),
    .test_clk_en_i (test_clk_en_i),
    .los_o         (los_o),
    .ref_sel_o     (ref_sel_o),
    .div_clk_o     (div_clk_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_line();
    line_i = ~line_i;
  endtask

  task automatic t_reset();
    rst = 1'b1; line_i = 1'b0; ana_los_i = 1'b0; sig_det_i = 1'b1;
    cmi_mode_i = 1'b1; test_clk_en_i = 1'b0;
    step(4);
    check("R1 los in reset", los_o, 1'b1);
    check("R1 ref_sel in reset", ref_sel_o, 1'b1);
    check("R1 div in reset", div_clk_o, 1'b0);
    rst = 1'b0;
    step(1);
    check("R1 los after reset", los_o, 1'b1);
    check("R1 ref_sel after reset", ref_sel_o, 1'b1);
  endtask

  task automatic t_clear();
    toggle_line();
    step(2);
    check("R4 los before clear", los_o, 1'b1);
    step(1);
    check("R4 los cleared", los_o, 1'b0);
    check("R8 ref_sel data", ref_sel_o, 1'b0);
  endtask

  task automatic t_timeout();
    toggle_line();
    step(95);
    check("R2 no early los", los_o, 1'b0);
    step(45);
    check("R2 los within window", los_o, 1'b1);
    check("R8 ref with los", ref_sel_o, 1'b1);
    step(300);
    check("R3 los holds", los_o, 1'b1);
    toggle_line();
    step(3);
    check("R4 recovery", los_o, 1'b0);
  endtask

  task automatic t_keepalive();
    int seen = 0;
    for (int p = 0; p < 5; p++) begin
      toggle_line();
      for (int c = 0; c < 80; c++) begin
        step(1);
        if (los_o) seen++;
      end
    end
    check_int("R2 keepalive 80-cycle toggles", seen, 0);
  endtask

  task automatic t_dense();
    int seen = 0;
    for (int c = 0; c < 200; c++) begin
      toggle_line();
      step(1);
      if (los_o || ref_sel_o) seen++;
    end
    check_int("R3 dense toggling keeps clear", seen, 0);
  endtask

  task automatic t_analog();
    toggle_line(); step(1);
    ana_los_i = 1'b1; step(1);
    check("R5 ana los", los_o, 1'b1);
    check("R5 ana ref", ref_sel_o, 1'b1);
    ana_los_i = 1'b0; step(1);
    check("R5 ana released", los_o, 1'b0);
  endtask

  task automatic t_test();
    toggle_line(); step(1);
    test_clk_en_i = 1'b1; step(1);
    check("R6 test ref", ref_sel_o, 1'b1);
    check("R6 test no los", los_o, 1'b0);
    test_clk_en_i = 1'b0; step(1);
    check("R8 test released", ref_sel_o, 1'b0);
  endtask

  task automatic t_sigdet();
    toggle_line(); step(1);
    cmi_mode_i = 1'b1; sig_det_i = 1'b0; step(1);
    check("R7 cmi ignores sigdet", ref_sel_o, 1'b0);
    cmi_mode_i = 1'b0; step(1);
    check("R7 nrz dark ref", ref_sel_o, 1'b1);
    check("R7 nrz dark no los", los_o, 1'b0);
    sig_det_i = 1'b1; step(1);
    check("R7 nrz light data", ref_sel_o, 1'b0);
    cmi_mode_i = 1'b1;
  endtask

  task automatic t_divider();
    int highs = 0;
    int rises = 0;
    logic prev = div_clk_o;
    for (int c = 0; c < 64; c++) begin
      step(1);
      if (div_clk_o) highs++;
      if (div_clk_o && !prev) rises++;
      prev = div_clk_o;
    end
    check_int("R9 div high time", highs, 32);
    check_int("R9 div rises", rises, 8);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_divider();
        t_clear();
        t_timeout();
        t_keepalive();
        t_dense();
        t_analog();
        t_test();
        t_sigdet();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule